// File: doc/BRIEF.md
# Sleep-Aware Receive Clock Gating Controller

This block is the mode controller for an auto-acknowledge receive path. It lets an attached microcontroller be powered down while the radio keeps listening. A rising edge on the sleep request input starts a fixed countdown. When the countdown ends, the enable for the clock that feeds the controller is dropped and the block enters a clockless listening state. If a start-of-frame delimiter arrives, the block follows the frame through address filtering. The controller clock comes back only when the frame is addressed to this node. If the sleep request is withdrawn, the clock also comes back.

Once a frame is accepted, the block requests an ACK transmission when the CRC is good and the frame asks for an acknowledgement. It then raises an end-of-transaction interrupt and returns to normal listening with the clock on. The clockless state is entered again only after the sleep request has been lowered and raised once more. Frame reception, address filtering and the ACK transmitter are outside this block; it only sees their strobes.

Top module: `rx_sleep_clkgate`

## Requirements
- R1: After reset, state_o is 0 (normal listen), clk_en_o is 1, and ack_tx_o and end_irq_o are 0.
- R2: A low-to-high change of sleep_req_i seen while in normal listen starts a countdown. Exactly GATE_DLY (default 35) clock edges after the edge that samples the change, clk_en_o goes to 0 and state_o becomes 1 (clockless listen).
- R3: If sleep_req_i goes low during the countdown, the countdown is cancelled: clk_en_o stays 1 and state_o stays 0. A later rising edge restarts the full count.
- R4: In clockless listen, a low sleep_req_i returns state_o to 0 with clk_en_o at 1 on the next edge. This takes priority over sfd_i.
- R5: In clockless listen, sfd_i moves state_o to 2 (clockless busy-receive) and clk_en_o stays 0.
- R6: In clockless busy-receive, addr_ok_i moves state_o to 3 (busy-receive) and sets clk_en_o to 1 on the same edge.
- R7: In clockless busy-receive, addr_fail_i returns state_o to 1. clk_en_o stays 0 and no interrupt is raised.
- R8: In busy-receive, rx_done_i with both crc_ok_i and ack_req_i high moves state_o to 4 (ACK transmit) and gives a one-cycle ack_tx_o pulse. A following ack_done_i returns state_o to 0 and gives a one-cycle end_irq_o pulse.
- R9: In busy-receive, rx_done_i with crc_ok_i or ack_req_i low returns state_o to 0. It gives a one-cycle end_irq_o pulse and no ack_tx_o.
- R10: After a transaction ends with sleep_req_i still high, the block stays in normal listen with the clock on. Gating resumes only after a fresh low-to-high edge.
- R11: In normal listen, sfd_i moves state_o to 3 with clk_en_o at 1 and cancels any pending countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_req_i | input | 1 | Sleep request level |
| sfd_i | input | 1 | Start-of-frame delimiter detected strobe |
| addr_ok_i | input | 1 | Address filter pass strobe |
| addr_fail_i | input | 1 | Address filter fail strobe |
| crc_ok_i | input | 1 | CRC valid, qualified by rx_done_i |
| ack_req_i | input | 1 | Frame requests ACK, qualified by rx_done_i |
| rx_done_i | input | 1 | Frame reception complete strobe |
| ack_done_i | input | 1 | ACK transmission complete strobe |
| clk_en_o | output | 1 | Registered enable for the controller clock output |
| ack_tx_o | output | 1 | One-cycle ACK transmit request |
| end_irq_o | output | 1 | One-cycle end-of-transaction interrupt |
| state_o | output | 3 | Current state: 0 listen, 1 clockless listen, 2 clockless busy, 3 busy, 4 ACK |

## Verification
The gating countdown is driven three ways: held high until it expires, dropped partway through, and interrupted by a frame start. Together these show the exact edge count, the cancel path and frame priority. Frames are then driven through the clockless path with address pass and address fail, and through the normal path with CRC and ACK-request combinations. This separates clock restoration from clock holding and the ACK path from the direct interrupt path. Leaving the sleep request high across the end of a transaction shows that only a fresh rising edge re-arms gating.

// File: rtl/rx_sleep_pkg.sv
package rx_sleep_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_LISTEN     = 3'd0,
    ST_NOCLK      = 3'd1,
    ST_BUSY_NOCLK = 3'd2,
    ST_BUSY       = 3'd3,
    ST_ACK        = 3'd4
  } rx_state_e;
endpackage

// File: rtl/sleep_gate_timer.sv
module sleep_gate_timer #(
  parameter int unsigned GATE_DLY = 35
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic arm_en_i,
  input  logic cancel_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(GATE_DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(GATE_DLY - 1);

  logic          prev_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise     = sleep_i & ~prev_q;
  assign expire_o = armed_q & sleep_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q <= sleep_i;
      if (!arm_en_i || cancel_i || !sleep_i || expire_o) begin
        armed_q <= 1'b0;
      end else if (rise) begin
        armed_q <= 1'b1;
        cnt_q   <= LOAD;
      end else if (armed_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r3_cancel_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !sleep_i |=> !armed_q);
  a_r2_load_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && arm_en_i && !cancel_i |=> armed_q && cnt_q == LOAD);
  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && sleep_i && arm_en_i && !cancel_i && cnt_q != '0
      |=> armed_q && cnt_q == $past(cnt_q) - 1'b1);
  a_r11_cancel_on_sfd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !armed_q);
endmodule

// File: rtl/rx_sleep_fsm.sv
module rx_sleep_fsm
  import rx_sleep_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_i,
  input  logic            expire_i,
  input  logic            sfd_i,
  input  logic            addr_ok_i,
  input  logic            addr_fail_i,
  input  logic            crc_ok_i,
  input  logic            ack_req_i,
  input  logic            rx_done_i,
  input  logic            ack_done_i,
  output rx_state_e       state_o,
  output logic            clk_en_o,
  output logic            ack_tx_o,
  output logic            end_irq_o
);
  rx_state_e state_q, state_d;
  logic      clk_en_q, ack_q, irq_q;
  logic      ack_d, irq_d;

  always_comb begin
    state_d = state_q;
    ack_d   = 1'b0;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_LISTEN: begin
        if (sfd_i)         state_d = ST_BUSY;
        else if (expire_i) state_d = ST_NOCLK;
      end
      ST_NOCLK: begin
        if (!sleep_i)   state_d = ST_LISTEN;
        else if (sfd_i) state_d = ST_BUSY_NOCLK;
      end
      ST_BUSY_NOCLK: begin
        if (addr_ok_i)        state_d = ST_BUSY;
        else if (addr_fail_i) state_d = ST_NOCLK;
      end
      ST_BUSY: begin
        if (rx_done_i) begin
          if (crc_ok_i && ack_req_i) begin
            state_d = ST_ACK;
            ack_d   = 1'b1;
          end else begin
            state_d = ST_LISTEN;
            irq_d   = 1'b1;
          end
        end
      end
      ST_ACK: begin
        if (ack_done_i) begin
          state_d = ST_LISTEN;
          irq_d   = 1'b1;
        end
      end
      default: state_d = ST_LISTEN;
    endcase
  end

  // clock enable registered from next state: changes only on an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_LISTEN;
      clk_en_q <= 1'b1;
      ack_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      clk_en_q <= !(state_d == ST_NOCLK || state_d == ST_BUSY_NOCLK);
      ack_q    <= ack_d;
      irq_q    <= irq_d;
    end
  end

  assign state_o   = state_q;
  assign clk_en_o  = clk_en_q;
  assign ack_tx_o  = ack_q;
  assign end_irq_o = irq_q;

  a_r2_gate_from_listen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_q) |-> $past(state_q) == ST_LISTEN && $past(expire_i));
  a_r6_restore_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_q) |-> $past(state_q) == ST_NOCLK || $past(state_q) == ST_BUSY_NOCLK);
  a_r8_ack_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> $past(state_q) == ST_BUSY && $past(crc_ok_i) && $past(ack_req_i));
  a_r9_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_q, irq_q}));
  a_r7_no_irq_clockless: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> clk_en_q && state_q == ST_LISTEN);
endmodule

// File: rtl/rx_sleep_clkgate.sv
module rx_sleep_clkgate
  import rx_sleep_pkg::*;
#(
  parameter int unsigned GATE_DLY = 35
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_req_i,
  input  logic            sfd_i,
  input  logic            addr_ok_i,
  input  logic            addr_fail_i,
  input  logic            crc_ok_i,
  input  logic            ack_req_i,
  input  logic            rx_done_i,
  input  logic            ack_done_i,
  output logic            clk_en_o,
  output logic            ack_tx_o,
  output logic            end_irq_o,
  output logic [ST_W-1:0] state_o
);
  rx_state_e state;
  logic      expire;
  logic      in_listen;

  assign in_listen = (state == ST_LISTEN);

  sleep_gate_timer #(.GATE_DLY(GATE_DLY)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_req_i),
    .arm_en_i (in_listen),
    .cancel_i (in_listen & sfd_i),
    .expire_o (expire)
  );

  rx_sleep_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_i     (sleep_req_i),
    .expire_i    (expire),
    .sfd_i       (sfd_i),
    .addr_ok_i   (addr_ok_i),
    .addr_fail_i (addr_fail_i),
    .crc_ok_i    (crc_ok_i),
    .ack_req_i   (ack_req_i),
    .rx_done_i   (rx_done_i),
    .ack_done_i  (ack_done_i),
    .state_o     (state),
    .clk_en_o    (clk_en_o),
    .ack_tx_o    (ack_tx_o),
    .end_irq_o   (end_irq_o)
  );

  assign state_o = state;
endmodule

// File: tb/rx_sleep_clkgate_tb_top.sv
module rx_sleep_clkgate_tb_top;
  localparam int DLY = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, sfd = 0, addr_ok = 0, addr_fail = 0;
  logic crc_ok = 0, ack_req = 0, rx_done = 0, ack_done = 0;
  logic clk_en, ack_tx, end_irq;
  logic [2:0] state;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_sleep_clkgate #(.GATE_DLY(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .sfd_i(sfd),
    .addr_ok_i(addr_ok), .addr_fail_i(addr_fail), .crc_ok_i(crc_ok),
    .ack_req_i(ack_req), .rx_done_i(rx_done), .ack_done_i(ack_done),
    .clk_en_o(clk_en), .ack_tx_o(ack_tx), .end_irq_o(end_irq), .state_o(state)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, int st, int ce, int ak, int irq);
    chk({req, " state"}, int'(state), st);
    chk({req, " clk_en"}, int'(clk_en), ce);
    chk({req, " ack_tx"}, int'(ack_tx), ak);
    chk({req, " end_irq"}, int'(end_irq), irq);
  endtask

  // raise sleep from low and wait for gating: R2
  task automatic go_sleep(string req);
    sleep_req = 1'b1;
    step(1);
    step(DLY - 1);
    chk_out({req, " before expiry"}, 0, 1, 0, 0);
    step(1);
    chk_out(req, 1, 0, 0, 0);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    step(1);
    sig = 1'b0;
  endtask

  task automatic t_reset;
    chk_out("R1 reset", 0, 1, 0, 0);
  endtask

  task automatic t_gate_and_wake;
    go_sleep("R2 gate");
    step(20);
    chk_out("R2 hold clockless", 1, 0, 0, 0);
    sleep_req = 1'b0;
    step(1);
    chk_out("R4 wake on low", 0, 1, 0, 0);
  endtask

  task automatic t_cancel;
    sleep_req = 1'b1;
    step(10);
    sleep_req = 1'b0;
    step(40);
    chk_out("R3 cancelled", 0, 1, 0, 0);
    go_sleep("R3 full restart");
    sleep_req = 1'b0;
    sfd = 1'b1;
    step(1);
    sfd = 1'b0;
    chk_out("R4 low beats sfd", 0, 1, 0, 0);
  endtask

  task automatic t_clockless_ack;
    go_sleep("R2 gate again");
    pulse(sfd);
    chk_out("R5 clockless busy", 2, 0, 0, 0);
    pulse(addr_ok);
    chk_out("R6 addr pass", 3, 1, 0, 0);
    crc_ok = 1; ack_req = 1;
    pulse(rx_done);
    crc_ok = 0; ack_req = 0;
    chk_out("R8 ack request", 4, 1, 1, 0);
    step(1);
    chk_out("R8 ack pulse ends", 4, 1, 0, 0);
    pulse(ack_done);
    chk_out("R8 end irq", 0, 1, 0, 1);
    step(1);
    chk_out("R8 irq pulse ends", 0, 1, 0, 0);
    step(60);
    chk_out("R10 no regate while high", 0, 1, 0, 0);
    sleep_req = 1'b0;
    step(1);
    go_sleep("R10 fresh edge regates");
  endtask

  task automatic t_addr_fail;
    pulse(sfd);
    chk_out("R5 clockless busy 2", 2, 0, 0, 0);
    pulse(addr_fail);
    chk_out("R7 addr fail", 1, 0, 0, 0);
    step(3);
    chk_out("R7 no irq", 1, 0, 0, 0);
    sleep_req = 1'b0;
    step(1);
    chk_out("R4 wake after fail", 0, 1, 0, 0);
  endtask

  task automatic t_normal_rx;
    sleep_req = 1'b1;
    step(5);
    pulse(sfd);
    chk_out("R11 sfd in listen", 3, 1, 0, 0);
    step(40);
    chk_out("R11 countdown cancelled", 3, 1, 0, 0);
    crc_ok = 1; ack_req = 0;
    pulse(rx_done);
    crc_ok = 0;
    chk_out("R9 no ack needed", 0, 1, 0, 1);
    step(1);
    chk_out("R9 irq one cycle", 0, 1, 0, 0);
    pulse(sfd);
    crc_ok = 0; ack_req = 1;
    pulse(rx_done);
    ack_req = 0;
    chk_out("R9 bad crc", 0, 1, 0, 1);
    step(50);
    chk_out("R10 held high no gate", 0, 1, 0, 0);
    sleep_req = 1'b0;
    step(1);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_gate_and_wake();
    t_cancel();
    t_clockless_ack();
    t_addr_fail();
    t_normal_rx();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule